// File: doc/BRIEF.md
# I2C Target Byte Engine with Event Flags

This block is the receiving end of a two-wire serial bus inside a microcontroller's serial interface. It samples the external clock and data lines, finds START and STOP conditions, collects a 7-bit address and a direction bit, and compares the address with a programmable own address. When the address matches, it acknowledges and then moves one byte per transfer. In the master-writes direction it places each received byte on `rx_byte`. In the master-reads direction it shifts out `tx_byte`. It drives the data line only by pulling it low, through `sda_oe`.

Three events share one sticky interrupt request: address match, byte completion and bus time-out. Software tells them apart with `addr_match`, which is set by a matching address and cleared by each completed data byte, and with `to_flag`. `irq_clr` clears the request and the time-out flag. A match seen while the device sleeps raises `wake_o`, but only if `wake_en` is set. `wake_o` stays high until software drops `wake_en`.

The controller has eight states: ST_IDLE, ST_ADDR (shift in address and direction), ST_AACK (acknowledge the address), ST_RX (shift in a data byte), ST_RACK (acknowledge a data byte), ST_TX (shift out a data byte), ST_TACK (sample the master's acknowledge) and ST_SKIP (ignore the bus).

Transitions:
- Any state goes to ST_IDLE when the block is disabled, on a time-out, or on a STOP.
- Any state goes to ST_ADDR on a START.
- ST_ADDR goes to ST_AACK on a match, or to ST_SKIP on a mismatch, at the clock fall after the eighth bit.
- ST_AACK goes to ST_TX or ST_RX, depending on the direction bit.
- ST_RX goes to ST_RACK after eight bits, and ST_RACK returns to ST_RX.
- ST_TX goes to ST_TACK after eight bits.
- ST_TACK goes to ST_TX on an acknowledge, or to ST_SKIP on a not-acknowledge.

Top module: `i2c_target_core`

## Requirements
- R1: The engine works only while `enable`=1 and `mode`=3'b110. Otherwise it stays idle: it never drives SDA and sets no flag.
- R2: A START (SDA falling while SCL is high) starts address reception from any state. This includes a repeated START in the middle of a transfer, with no STOP before it.
- R3: The seven bits after START form the address, most significant bit first. The eighth bit is stored in `dir_rd` on a match: 1 means the master reads, 0 means the master writes.
- R4: On an address equal to `own_addr`, `addr_match` and `irq` become 1, and SDA is held low during the ninth clock.
- R5: On a mismatch there is no acknowledge, no flag change and no interrupt until the next START.
- R6: In write direction each 8-bit byte appears on `rx_byte` and is acknowledged. It sets `irq` and clears `addr_match`.
- R7: In read direction the byte on `tx_byte` is sent most significant bit first. `tx_byte` is sampled at the clock fall that ends the preceding acknowledge, and a 1 bit leaves SDA released.
- R8: In read direction `rx_nack` takes SDA on the ninth clock and `irq` is set. On 0 the next byte follows. On 1 SDA stays released until the next START.
- R9: After a STOP, clocks without a new START are ignored.
- R10: If SCL stays low for more than `to_limit` consecutive system clocks during a transfer, `to_flag` and `irq` are set and the engine returns to idle.
- R11: A pulse on `irq_clr` clears `irq` and `to_flag`.
- R12: An address match while `sleep`=1 and `wake_en`=1 sets `wake_o`. It stays 1 until `wake_en` is 0.
- R13: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| enable | input | 1 | Interface enable |
| mode | input | 3 | Interface mode, 3'b110 selects this engine |
| own_addr | input | 7 | Own bus address |
| tx_byte | input | 8 | Byte to send to the master |
| rx_byte | output | 8 | Last byte received from the master |
| addr_match | output | 1 | Address matched, cleared by a completed data byte |
| dir_rd | output | 1 | Direction of the last matched address, 1 = master reads |
| rx_nack | output | 1 | Master's acknowledge level after a sent byte |
| to_flag | output | 1 | Bus time-out occurred |
| irq | output | 1 | Sticky interrupt request |
| irq_clr | input | 1 | Clears `irq` and `to_flag` |
| wake_en | input | 1 | Address-match wake-up enable |
| sleep | input | 1 | Device is in a low-power mode |
| wake_o | output | 1 | Wake-up request |
| to_limit | input | TO_W | Time-out threshold in system clocks |

## Verification
A wrong state in this engine shows at the ports within one bus bit, so the bench compares every flag and `rx_byte` against its model at the end of each bus phase.
- A wrong bit count or a wrong state shows as a missing or misplaced acknowledge on the ninth clock, or as a shifted `rx_byte`.
- A stuck ST_TX shows as data bits being driven after a not-acknowledge.
- A lost ST_SKIP shows as acknowledges to a foreign address.

Time-out and wake-up faults show in the sticky flags within a few clocks of the triggering condition.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    localparam int ADDR_W = 7;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [2:0] MODE_I2C = 3'b110;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_AACK, ST_RX, ST_RACK, ST_TX, ST_TACK, ST_SKIP
    } tgt_state_t;
endpackage

// File: rtl/i2c_tgt_linesync.sv
module i2c_tgt_linesync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-1:0], din};
    end

    assign lvl  = pipe[STAGES-1];
    assign rise = pipe[STAGES-1] & ~pipe[STAGES];
    assign fall = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/i2c_tgt_lowtimer.sv
module i2c_tgt_lowtimer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (!run)       cnt <= '0;
        else if (cnt != '1)  cnt <= cnt + 1'b1;
    end

    assign hit = run && (cnt == limit);
endmodule

// File: rtl/i2c_target_core.sv
module i2c_target_core
    import i2c_tgt_pkg::*;
#(
    parameter int TO_W      = 16,
    parameter int SYNC_FLOPS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                sda_oe,
    input  logic                enable,
    input  logic [2:0]          mode,
    input  logic [ADDR_W-1:0]   own_addr,
    input  logic [BYTE_W-1:0]   tx_byte,
    output logic [BYTE_W-1:0]   rx_byte,
    output logic                addr_match,
    output logic                dir_rd,
    output logic                rx_nack,
    output logic                to_flag,
    output logic                irq,
    input  logic                irq_clr,
    input  logic                wake_en,
    input  logic                sleep,
    output logic                wake_o,
    input  logic [TO_W-1:0]     to_limit
);
    localparam int LINES = 2;   // index 0: SCL, index 1: SDA

    logic [LINES-1:0] line_in, line_lvl, line_rise, line_fall;
    assign line_in = {sda_i, scl_i};

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_sync
            i2c_tgt_linesync #(.STAGES(SYNC_FLOPS)) u_sync (
                .clk(clk), .rst_n(rst_n), .din(line_in[g]),
                .lvl(line_lvl[g]), .rise(line_rise[g]), .fall(line_fall[g])
            );
        end
    endgenerate

    logic scl_lvl, scl_rise, scl_fall, sda_lvl;
    assign scl_lvl  = line_lvl[0];
    assign scl_rise = line_rise[0];
    assign scl_fall = line_fall[0];
    assign sda_lvl  = line_lvl[1];

    logic active, bus_start, bus_stop;
    assign active    = enable && (mode == MODE_I2C);
    assign bus_start = active && scl_lvl && line_fall[1];
    assign bus_stop  = scl_lvl && line_rise[1];

    tgt_state_t        st, st_n;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] sh;
    logic              byte_done, addr_hit, ev_addr, ev_byte, to_hit, lowrun;

    assign byte_done = (bit_cnt == CNT_W'(BYTE_W));
    assign addr_hit  = (sh[BYTE_W-1:1] == own_addr);
    assign lowrun    = active && !scl_lvl && (st != ST_IDLE) && (st != ST_SKIP);

    i2c_tgt_lowtimer #(.W(TO_W)) u_lowtimer (
        .clk(clk), .rst_n(rst_n), .run(lowrun), .limit(to_limit), .hit(to_hit)
    );

    // next-state and event decode
    always_comb begin
        st_n    = st;
        ev_addr = 1'b0;
        ev_byte = 1'b0;
        if (!active || to_hit)  st_n = ST_IDLE;
        else if (bus_start)     st_n = ST_ADDR;
        else if (bus_stop)      st_n = ST_IDLE;
        else begin
            unique case (st)
                ST_IDLE, ST_SKIP: st_n = st;
                ST_ADDR: if (scl_fall && byte_done) begin
                    ev_addr = addr_hit;
                    st_n    = addr_hit ? ST_AACK : ST_SKIP;
                end
                ST_AACK: if (scl_fall) st_n = dir_rd ? ST_TX : ST_RX;
                ST_RX: if (scl_fall && byte_done) begin
                    ev_byte = 1'b1;
                    st_n    = ST_RACK;
                end
                ST_RACK: if (scl_fall) st_n = ST_RX;
                ST_TX:   if (scl_fall && byte_done) st_n = ST_TACK;
                ST_TACK: begin
                    if (scl_rise) ev_byte = 1'b1;
                    if (scl_fall) st_n = rx_nack ? ST_SKIP : ST_TX;
                end
                default: st_n = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    // shift path and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            sh      <= '0;
        end else if (bus_start) begin
            bit_cnt <= '0;
        end else begin
            unique case (st)
                ST_ADDR, ST_RX: if (scl_rise) begin
                    sh      <= {sh[BYTE_W-2:0], sda_lvl};
                    bit_cnt <= bit_cnt + 1'b1;
                end
                ST_TX: begin
                    if (scl_rise)      bit_cnt <= bit_cnt + 1'b1;
                    else if (scl_fall) sh <= {sh[BYTE_W-2:0], 1'b1};
                end
                ST_AACK, ST_TACK: if (scl_fall) begin
                    bit_cnt <= '0;
                    sh      <= tx_byte;
                end
                ST_RACK: if (scl_fall) bit_cnt <= '0;
                default: ;
            endcase
        end
    end

    // status flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_match <= 1'b0;
            dir_rd     <= 1'b0;
            rx_nack    <= 1'b0;
            to_flag    <= 1'b0;
            irq        <= 1'b0;
            rx_byte    <= '0;
            wake_o     <= 1'b0;
        end else begin
            if (ev_addr) begin
                addr_match <= 1'b1;
                dir_rd     <= sh[0];
            end else if (ev_byte) begin
                addr_match <= 1'b0;
            end
            if (ev_byte && st == ST_RX)   rx_byte <= sh;
            if (ev_byte && st == ST_TACK) rx_nack <= sda_lvl;
            if (to_hit)       to_flag <= 1'b1;
            else if (irq_clr) to_flag <= 1'b0;
            if (ev_addr || ev_byte || to_hit) irq <= 1'b1;
            else if (irq_clr)                 irq <= 1'b0;
            if (!wake_en)                wake_o <= 1'b0;
            else if (ev_addr && sleep)   wake_o <= 1'b1;
        end
    end

    // open-drain output decode
    always_comb begin
        unique case (st)
            ST_AACK, ST_RACK: sda_oe = 1'b1;
            ST_TX:            sda_oe = ~sh[BYTE_W-1];
            default:          sda_oe = 1'b0;
        endcase
    end

    // R1
    inactive_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !sda_oe);
    // R4
    match_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_match) |-> sda_oe);
    // R5
    skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SKIP && $past(st) == ST_SKIP) |-> ($stable(addr_match) && $stable(rx_byte)));
    // R10
    timeout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(to_flag) |-> (st == ST_IDLE));
    // R12
    wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_o) |-> ($past(sleep) && $past(wake_en)));
endmodule

// File: tb/test_i2c_target_core.sv
module test_i2c_target_core;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 8;
    localparam int TO_W = 16;
    localparam int M_IDLE = 0, M_RX = 1, M_TX = 2, M_SKIP = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic sda_oe, bus_sda;
    logic en = 1'b0, irq_clr = 1'b0, wake_en = 1'b0, sleep = 1'b0;
    logic [2:0] md = 3'b000;
    logic [6:0] own = 7'h3A;
    logic [7:0] tx_byte = 8'h00, rx_byte;
    logic addr_match, dir_rd, rx_nack, to_flag, irq, wake_o;
    logic [TO_W-1:0] to_limit = 16'd40;

    int vectors = 0, miscompares = 0;
    bit done = 1'b0;

    // behavioural reference state
    logic e_am = 0, e_dir = 0, e_nack = 0, e_to = 0, e_irq = 0, e_wake = 0;
    logic [7:0] e_rx = 8'h00, e_txload = 8'h00;
    int bmode = M_IDLE;

    assign bus_sda = m_sda & ~sda_oe;
    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_target_core #(.TO_W(TO_W)) i_i2c_target_core (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus_sda), .sda_oe(sda_oe),
        .enable(en), .mode(md), .own_addr(own), .tx_byte(tx_byte), .rx_byte(rx_byte),
        .addr_match(addr_match), .dir_rd(dir_rd), .rx_nack(rx_nack), .to_flag(to_flag),
        .irq(irq), .irq_clr(irq_clr), .wake_en(wake_en), .sleep(sleep), .wake_o(wake_o),
        .to_limit(to_limit)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic cmp(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        cmp(req, "addr_match", {7'd0, addr_match}, {7'd0, e_am});
        cmp(req, "dir_rd", {7'd0, dir_rd}, {7'd0, e_dir});
        cmp(req, "rx_nack", {7'd0, rx_nack}, {7'd0, e_nack});
        cmp(req, "to_flag", {7'd0, to_flag}, {7'd0, e_to});
        cmp(req, "irq", {7'd0, irq}, {7'd0, e_irq});
        cmp(req, "wake_o", {7'd0, wake_o}, {7'd0, e_wake});
        cmp(req, "rx_byte", rx_byte, e_rx);
    endtask

    function automatic bit b_active();
        return en && (md == 3'b110);
    endfunction

    task automatic clock_bit(input logic b, output logic smp);
        m_sda = b;  tick(Q);
        m_scl = 1;  tick(Q);
        smp = bus_sda; tick(Q);
        m_scl = 0;  tick(Q);
    endtask

    task automatic bus_start();
        m_sda = 1; tick(Q);
        m_scl = 1; tick(Q);
        m_sda = 0; tick(Q);
        m_scl = 0; tick(Q);
        bmode = M_IDLE;
    endtask

    task automatic bus_stop();
        m_sda = 0; tick(Q);
        m_scl = 1; tick(Q);
        m_sda = 1; tick(Q);
        bmode = M_IDLE;
    endtask

    task automatic pulse_clr();
        irq_clr = 1; tick(1);
        irq_clr = 0; tick(1);
        e_irq = 0; e_to = 0;
    endtask

    task automatic addr_phase(input logic [6:0] a, input logic rw, input string req);
        logic s;
        bit match;
        match = b_active() && (a == own);
        for (int i = 6; i >= 0; i--) clock_bit(a[i], s);
        clock_bit(rw, s);
        if (match) begin
            e_am = 1; e_dir = rw; e_irq = 1;
            if (sleep && wake_en) e_wake = 1;
            bmode = rw ? M_TX : M_RX;
        end else bmode = M_SKIP;
        check_all(req);
        clock_bit(1'b1, s);
        cmp(req, "address ack level", {7'd0, s}, match ? 8'd0 : 8'd1);
        if (match && rw) e_txload = tx_byte;
    endtask

    task automatic write_byte(input logic [7:0] b, input string req);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        if (bmode == M_RX) begin
            e_rx = b; e_am = 0; e_irq = 1;
        end
        check_all(req);
        clock_bit(1'b1, s);
        cmp(req, "data ack level", {7'd0, s}, (bmode == M_RX) ? 8'd0 : 8'd1);
    endtask

    task automatic read_byte(input logic nack, input string req);
        logic s;
        logic [7:0] got, exp;
        exp = (bmode == M_TX) ? e_txload : 8'hFF;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            got[i] = s;
        end
        cmp(req, "read data", got, exp);
        clock_bit(nack, s);
        if (bmode == M_TX) begin
            e_nack = nack; e_am = 0; e_irq = 1;
            if (nack) bmode = M_SKIP;
            else e_txload = tx_byte;
        end
        check_all(req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        tick(3);
        // R13 reset state
        cmp("R13", "sda_oe", {7'd0, sda_oe}, 8'd0);
        check_all("R13");
        rst_n = 1; tick(4);
        en = 1; md = 3'b110;

        // R2 R3 R4 R6 write transfer
        bus_start();
        addr_phase(7'h3A, 1'b0, "R4");
        write_byte(8'hA5, "R6");
        write_byte(8'h5C, "R6");
        pulse_clr();
        check_all("R11");
        bus_stop();

        // R5 foreign address ignored
        bus_start();
        addr_phase(7'h3B, 1'b0, "R5");
        write_byte(8'h0F, "R5");
        bus_stop();
        check_all("R5");

        // R7 R8 read transfer
        tx_byte = 8'hC3;
        bus_start();
        addr_phase(7'h3A, 1'b1, "R3");
        tx_byte = 8'h96;
        read_byte(1'b0, "R7");
        read_byte(1'b1, "R8");
        read_byte(1'b1, "R8");
        bus_stop();
        pulse_clr();

        // R9 clocks after STOP ignored
        m_scl = 0; tick(Q);
        write_byte(8'h00, "R9");
        check_all("R9");

        // R2 repeated START mid-transfer
        bus_start();
        addr_phase(7'h3A, 1'b0, "R2");
        write_byte(8'h11, "R2");
        pulse_clr();
        tx_byte = 8'h4E;
        bus_start();
        addr_phase(7'h3A, 1'b1, "R2");
        read_byte(1'b1, "R2");
        bus_stop();

        // R10 SCL held low, then R11 clear
        pulse_clr();
        bus_start();
        addr_phase(7'h3A, 1'b0, "R10");
        tick(60);
        e_to = 1; e_irq = 1; bmode = M_IDLE;
        check_all("R10");
        write_byte(8'h77, "R10");
        pulse_clr();
        check_all("R11");
        bus_stop();

        // R1 disabled by mode and by enable
        md = 3'b101;
        bus_start();
        addr_phase(7'h3A, 1'b0, "R1");
        bus_stop();
        md = 3'b110; en = 0;
        bus_start();
        addr_phase(7'h3A, 1'b0, "R1");
        bus_stop();
        en = 1;
        check_all("R1");

        // R12 wake-up
        sleep = 1; wake_en = 1;
        bus_start();
        addr_phase(7'h3A, 1'b0, "R12");
        bus_stop();
        check_all("R12");
        wake_en = 0; tick(2);
        e_wake = 0;
        check_all("R12");
        bus_start();
        addr_phase(7'h3A, 1'b0, "R12");
        bus_stop();
        sleep = 0; wake_en = 1;
        bus_start();
        addr_phase(7'h3A, 1'b0, "R12");
        bus_stop();
        check_all("R12");

        finish_run();
    end
endmodule